// File: doc/BRIEF.md
# Packed 64-bit Multimedia Execute Unit

This block is a single-stage execute datapath for packed integer work on two 64-bit operands. A two-bit opcode selects one of three operations. The first multiplies matching unsigned 16-bit words and keeps the upper half of each product. The second takes the absolute difference of each of the eight byte pairs and adds the differences into one 16-bit total. The third rearranges the four words of the first operand under control of an 8-bit immediate, and any source word may go to any result position.

The block sits behind operand read and ahead of writeback in a pipeline. Each cycle the caller presents an opcode, both operands, the immediate and a valid strobe. One clock later the block returns a registered 64-bit result and a result strobe. It takes a new operation every cycle and never stalls.

Top module: `pk64_exec`

## Requirements
- R1: While `rst` is high at a rising clock edge, `out_valid` and `result` are 0 after that edge.
- R2: `out_valid` is high in the cycle after a clock edge that sampled `in_valid` high, and low after an edge that sampled it low. Back-to-back operations are each accepted.
- R3: Opcode 0 (high multiply): result word i (bits 16i+15:16i) equals bits 31:16 of the unsigned product of word i of `src_a` and word i of `src_b`.
- R4: Opcode 1 (byte SAD): result bits 15:0 equal the sum over the eight bytes j of |byte j of `src_a` - byte j of `src_b`|, with both bytes taken as unsigned.
- R5: For opcode 1, result bits 63:16 are zero, and the sum never saturates: all-0x00 against all-0xFF gives 2040 (0x07F8).
- R6: Opcode 2 (word shuffle): result word i equals word `imm[2i+1:2i]` of `src_a` for i = 0..3, and `src_b` has no effect on the result.
- R7: Opcode 3 is reserved and produces a result of zero.
- R8: After a clock edge that sampled `in_valid` low, `result` keeps its previous value, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation present on the inputs this cycle |
| op | input | 2 | Operation select: 0 high multiply, 1 byte SAD, 2 word shuffle, 3 reserved |
| src_a | input | 64 | First packed operand |
| src_b | input | 64 | Second packed operand |
| imm | input | 8 | Shuffle selectors, two bits per result word |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| result | output | 64 | Registered packed result |

## Verification
The assertions watch the timing contract on every cycle: the one-cycle strobe delay, the clearing on reset, the result holding while idle, the zero upper bits of an SAD result, the zero result for the reserved opcode, and the bound on the SAD sum. The lane arithmetic is a different matter. The correct high-half products, the byte differences and the shuffle routing for particular immediates only show up in the bench's scenarios. There, random operands and directed extremes (all-ones words, fully opposite bytes, reversed and broadcast shuffles) are compared with values computed in the bench.

// File: rtl/pk64_pkg.sv
package pk64_pkg;

    localparam int PK_DATA_W = 64;
    localparam int PK_WORD_W = 16;
    localparam int PK_BYTE_W = 8;
    localparam int PK_SUM_W  = 16;
    localparam int PK_WORDS  = PK_DATA_W / PK_WORD_W;
    localparam int PK_BYTES  = PK_DATA_W / PK_BYTE_W;
    localparam int PK_SEL_W  = $clog2(PK_WORDS);
    localparam int PK_IMM_W  = PK_WORDS * PK_SEL_W;

    typedef enum logic [1:0] {
        OP_MULHI = 2'd0,
        OP_SAD   = 2'd1,
        OP_SHUF  = 2'd2,
        OP_RSVD  = 2'd3
    } pk_op_e;

    typedef struct packed {
        pk_op_e                 op;
        logic [PK_DATA_W-1:0]   a;
        logic [PK_DATA_W-1:0]   b;
        logic [PK_IMM_W-1:0]    imm;
    } pk_req_t;

    function automatic logic [PK_BYTE_W-1:0] pk_absdiff(
        input logic [PK_BYTE_W-1:0] x,
        input logic [PK_BYTE_W-1:0] y
    );
        return (x >= y) ? (x - y) : (y - x);
    endfunction

endpackage

// File: rtl/pk64_mulhi.sv
module pk64_mulhi
    import pk64_pkg::*;
#(
    parameter int DATA_W = PK_DATA_W,
    parameter int WORD_W = PK_WORD_W
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    localparam int LANES = DATA_W / WORD_W;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [2*WORD_W-1:0] prod;
        assign prod = {{WORD_W{1'b0}}, a[i*WORD_W +: WORD_W]}
                    * {{WORD_W{1'b0}}, b[i*WORD_W +: WORD_W]};
        assign y[i*WORD_W +: WORD_W] = prod[2*WORD_W-1:WORD_W];
    end

endmodule

// File: rtl/pk64_sad.sv
module pk64_sad
    import pk64_pkg::*;
#(
    parameter int DATA_W = PK_DATA_W,
    parameter int BYTE_W = PK_BYTE_W,
    parameter int SUM_W  = PK_SUM_W
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    localparam int NBYTES  = DATA_W / BYTE_W;
    localparam int MAX_SUM = NBYTES * ((1 << BYTE_W) - 1);

    logic [BYTE_W-1:0] diff [NBYTES];
    logic [SUM_W-1:0]  acc;

    for (genvar j = 0; j < NBYTES; j++) begin : g_byte
        assign diff[j] = pk_absdiff(a[j*BYTE_W +: BYTE_W], b[j*BYTE_W +: BYTE_W]);
    end

    always_comb begin
        acc = '0;
        for (int j = 0; j < NBYTES; j++) begin
            acc = acc + SUM_W'(diff[j]);
        end
    end

    always_comb begin
        a_r5_sum_bound: assert (32'(acc) <= 32'(MAX_SUM));
    end

    assign y = {{(DATA_W-SUM_W){1'b0}}, acc};

endmodule

// File: rtl/pk64_shuf.sv
module pk64_shuf
    import pk64_pkg::*;
#(
    parameter int DATA_W = PK_DATA_W,
    parameter int WORD_W = PK_WORD_W
) (
    input  logic [DATA_W-1:0]                          x,
    input  logic [(DATA_W/WORD_W)*$clog2(DATA_W/WORD_W)-1:0] sel,
    output logic [DATA_W-1:0]                          y
);
    localparam int LANES = DATA_W / WORD_W;
    localparam int SEL_W = $clog2(LANES);

    for (genvar i = 0; i < LANES; i++) begin : g_dst
        logic [SEL_W-1:0] src;
        assign src = sel[i*SEL_W +: SEL_W];
        assign y[i*WORD_W +: WORD_W] = x[int'(src)*WORD_W +: WORD_W];
    end

endmodule

// File: rtl/pk64_exec.sv
module pk64_exec
    import pk64_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [1:0]            op,
    input  logic [PK_DATA_W-1:0]  src_a,
    input  logic [PK_DATA_W-1:0]  src_b,
    input  logic [PK_IMM_W-1:0]   imm,
    output logic                  out_valid,
    output logic [PK_DATA_W-1:0]  result
);
    pk_req_t               req;
    logic [PK_DATA_W-1:0]  mul_y;
    logic [PK_DATA_W-1:0]  sad_y;
    logic [PK_DATA_W-1:0]  shf_y;
    logic [PK_DATA_W-1:0]  next_y;

    assign req.op  = pk_op_e'(op);
    assign req.a   = src_a;
    assign req.b   = src_b;
    assign req.imm = imm;

    pk64_mulhi #(.DATA_W(PK_DATA_W), .WORD_W(PK_WORD_W)) u_mulhi (
        .a (req.a), .b (req.b), .y (mul_y)
    );

    pk64_sad #(.DATA_W(PK_DATA_W), .BYTE_W(PK_BYTE_W), .SUM_W(PK_SUM_W)) u_sad (
        .a (req.a), .b (req.b), .y (sad_y)
    );

    pk64_shuf #(.DATA_W(PK_DATA_W), .WORD_W(PK_WORD_W)) u_shuf (
        .x (req.a), .sel (req.imm), .y (shf_y)
    );

    always_comb begin
        unique case (req.op)
            OP_MULHI: next_y = mul_y;
            OP_SAD:   next_y = sad_y;
            OP_SHUF:  next_y = shf_y;
            default:  next_y = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= next_y;
            end
        end
    end

    // R1: reset clears both outputs
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!out_valid && result == '0));

    // R2: strobe follows input valid by one cycle
    a_r2_valid_rise: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r2_valid_low: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R8: idle cycles leave the result untouched
    a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));

    // R5: SAD result upper bits stay clear
    a_r5_sad_upper: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == OP_SAD) |=> (result[PK_DATA_W-1:PK_SUM_W] == '0));

    // R7: reserved opcode yields zero
    a_r7_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == OP_RSVD) |=> (result == '0));

endmodule

// File: tb/pk64_exec_bench.sv
module pk64_exec_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [1:0]  op;
    logic [63:0] src_a;
    logic [63:0] src_b;
    logic [7:0]  imm;
    logic        out_valid;
    logic [63:0] result;

    int checks = 0;
    int fails  = 0;
    logic [63:0] model_q;

    always #10 clk = ~clk;

    pk64_exec u_pk64_exec (
        .clk (clk), .rst (rst), .in_valid (in_valid), .op (op),
        .src_a (src_a), .src_b (src_b), .imm (imm),
        .out_valid (out_valid), .result (result)
    );

    function automatic logic [63:0] ref_mulhi(input logic [63:0] a, input logic [63:0] b);
        logic [63:0] r;
        for (int i = 0; i < 4; i++) begin
            logic [31:0] p;
            p = 32'(a[16*i +: 16]) * 32'(b[16*i +: 16]);
            r[16*i +: 16] = p[31:16];
        end
        return r;
    endfunction

    function automatic logic [63:0] ref_sad(input logic [63:0] a, input logic [63:0] b);
        int s = 0;
        for (int j = 0; j < 8; j++) begin
            int x, y;
            x = int'(a[8*j +: 8]);
            y = int'(b[8*j +: 8]);
            s += (x > y) ? x - y : y - x;
        end
        return 64'(s);
    endfunction

    function automatic logic [63:0] ref_shuf(input logic [63:0] a, input logic [7:0] s);
        logic [63:0] r;
        for (int i = 0; i < 4; i++) begin
            r[16*i +: 16] = a[16 * int'(s[2*i +: 2]) +: 16];
        end
        return r;
    endfunction

    function automatic logic [63:0] ref_op(input logic [1:0] o, input logic [63:0] a,
                                           input logic [63:0] b, input logic [7:0] s);
        case (o)
            2'd0:    return ref_mulhi(a, b);
            2'd1:    return ref_sad(a, b);
            2'd2:    return ref_shuf(a, s);
            default: return 64'd0;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive at falling edge, let one rising edge capture, check at next falling edge.
    task automatic apply(input logic v, input logic [1:0] o, input logic [63:0] a,
                         input logic [63:0] b, input logic [7:0] s, input string tag);
        in_valid = v; op = o; src_a = a; src_b = b; imm = s;
        @(posedge clk);
        @(negedge clk);
        if (v) model_q = ref_op(o, a, b, s);
        check(out_valid == v, "R2 strobe", 64'(out_valid), 64'(v));
        check(result == model_q, tag, result, model_q);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd24601));
        rst = 1'b1; in_valid = 1'b1; op = 2'd2;
        src_a = 64'h1234_5678_9abc_def0; src_b = '1; imm = 8'hE4;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 reset valid", 64'(out_valid), 64'd0);
        check(result == 64'd0, "R1 reset result", result, 64'd0);
        rst = 1'b0;
        model_q = '0;

        // R3 corners
        apply(1, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00, "R3 all ones");
        check(result == 64'hFFFE_FFFE_FFFE_FFFE, "R3 ffff*ffff", result, 64'hFFFE_FFFE_FFFE_FFFE);
        apply(1, 2'd0, 64'h8000_0001_FFFF_0100, 64'h0002_FFFF_0000_0100, 8'h00, "R3 mixed lanes");
        // R4/R5 corners
        apply(1, 2'd1, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00, "R5 max sum");
        check(result == 64'h7F8, "R5 2040", result, 64'h7F8);
        apply(1, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 8'h00, "R4 reversed order");
        apply(1, 2'd1, 64'h0102_0304_0506_0708, 64'h0807_0605_0403_0201, 8'h00, "R4 small diffs");
        apply(1, 2'd1, 64'hDEAD_BEEF_0BAD_F00D, 64'hDEAD_BEEF_0BAD_F00D, 8'h00, "R4 equal operands");
        // R6 corners
        apply(1, 2'd2, 64'h4444_3333_2222_1111, 64'h0, 8'h1B, "R6 reverse");
        check(result == 64'h1111_2222_3333_4444, "R6 reverse words", result, 64'h1111_2222_3333_4444);
        apply(1, 2'd2, 64'h4444_3333_2222_1111, 64'hFFFF_FFFF_FFFF_FFFF, 8'h1B, "R6 src_b ignored");
        apply(1, 2'd2, 64'h4444_3333_2222_1111, 64'h0, 8'hFF, "R6 broadcast top");
        apply(1, 2'd2, 64'h4444_3333_2222_1111, 64'h0, 8'hE4, "R6 identity");
        // R7
        apply(1, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 8'hFF, "R7 reserved");
        apply(1, 2'd0, 64'h0003_0003_0003_0003, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00, "R3 set before idle");
        // R8 idle with changing inputs
        apply(0, 2'd1, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 8'h55, "R8 hold sad");
        apply(0, 2'd3, 64'h1, 64'h2, 8'hAA, "R8 hold rsvd");

        // Random mix
        for (int n = 0; n < 600; n++) begin
            logic v;
            logic [63:0] a, b;
            v = ($urandom % 4) != 0;
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            if ($urandom % 8 == 0) a = '1;
            if ($urandom % 8 == 0) b = '0;
            apply(v, 2'($urandom), a, b, 8'($urandom),
                  v ? "R3/R4/R6/R7 random op" : "R8 random idle");
        end

        // R1 mid-run reset
        in_valid = 1'b1; op = 2'd0; src_a = '1; src_b = '1; rst = 1'b1;
        @(posedge clk); @(negedge clk);
        check(out_valid == 1'b0, "R1 mid-run valid", 64'(out_valid), 64'd0);
        check(result == 64'd0, "R1 mid-run result", result, 64'd0);
        rst = 1'b0; model_q = '0;
        apply(1, 2'd1, 64'h00FF, 64'hFF00, 8'h00, "R2 after reset");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule